// File: doc/BRIEF.md
# Serial Control Register Slave with Auto-Increment

This block is a two-wire serial slave that lets a host controller load a bank of 25 byte-wide control registers and read back a set of status bytes. It runs on a fast system clock and oversamples the bus clock and data lines through a two-stage synchronizer. It detects START and STOP, decodes the device address and then walks a register pointer that advances by one after every byte. The open-drain data pull-down is an output enable: when the enable is high, the pad pulls the line low.

The device address is the fixed prefix `10110` followed by two strap pins, which gives four possible addresses. Registers are written through shadow storage. A group of registers that together form one wider value (registers 3 to 5 and 6 to 8 by default) only reaches the live outputs once its highest byte has been acknowledged, so the core never sees a half-updated word. Subaddress 255 is a preset register. A byte written there is stored and also reloads registers 3 to 10 with derived values. The pointer never wraps, and the slave answers NACK to any target outside the valid set.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal `10110` followed by `addr_sel[1:0]`. It acknowledges no other address, including the all-zero broadcast address.
- R2: In a write frame (address with R/W bit 0, then subaddress, then data bytes), each data byte to a valid target is acknowledged and stored at the pointer. The pointer then advances by one.
- R3: Valid targets are 0 to 24 and 255. A subaddress or data byte aimed anywhere else is answered with NACK and writes nothing. The pointer does not wrap, so a byte following one written to 24 or 255 is refused.
- R4: Registers 3–5 and 6–8 form groups. A byte written into a group changes no output until the group's highest register has been acknowledged within the same frame. At that point every group member takes its newest value. Members not written in that frame keep their live value.
- R5: A byte that is cut off by a STOP before its acknowledge clock has no effect.
- R6: A byte D written to subaddress 255 appears on `esp_out`. It also sets register k to D + k, modulo 256, for every k from 3 to 10.
- R7: In a read frame (R/W bit 1), the slave returns `status_in[8k+7:8k]` for pointer k, most significant bit first, when k < 8. It returns 0x00 for any larger k. The pointer advances after each byte. A master ACK continues the read and a master NACK ends it.
- R8: The slave turns its pull-down on only while the synchronized bus clock is low. It releases the pull-down after every START and STOP.
- R9: After reset, all registers and `esp_out` are 0 and the pull-down is off.
- R10: Register outputs change only in the cycle after a committed write. Read frames and refused bytes leave them untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 2 | Strap pins forming the low two device-address bits |
| status_in | input | 64 | Eight status bytes, byte k at bits 8k+7:8k |
| sda_oe | output | 1 | Pull-down enable for the data line |
| regs_out | output | 200 | Live registers, register k at bits 8k+7:8k |
| esp_out | output | 8 | Last byte written to subaddress 255 |

## Verification
The bench builds the block with its default parameters: 25 registers, 8 status bytes and two three-byte groups. With only eight status bytes, a read can be run past the end of the status set. The small address space lets the bench sweep all 128 device addresses and all 256 subaddresses, so every acknowledge decision is checked against the arithmetic validity rule. The two groups let the bench stop a frame part-way through a group and inspect the live outputs between the acknowledges of a single frame.

// File: rtl/i2c_ctrl_pkg.sv
package i2c_ctrl_pkg;

    localparam int NREG     = 25;
    localparam int NSTAT    = 8;
    localparam int PTR_W    = 9;
    localparam int ESP_ADDR = 255;
    localparam int ESP_LO   = 3;
    localparam int ESP_HI   = 10;
    localparam logic [4:0] DEV_PREFIX = 5'b10110;

    localparam int NGRP = 2;
    localparam int GRP_LO [NGRP] = '{3, 6};
    localparam int GRP_HI [NGRP] = '{5, 8};

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
    } frame_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
    } bus_evt_t;

    typedef struct packed {
        logic             en;
        logic [PTR_W-1:0] addr;
        logic [7:0]       data;
    } wr_req_t;

    function automatic logic target_ok(input logic [PTR_W-1:0] a);
        return (int'(a) < NREG) || (int'(a) == ESP_ADDR);
    endfunction

    function automatic int grp_first(input int idx);
        int r;
        r = idx;
        for (int g = 0; g < NGRP; g++)
            if (idx >= GRP_LO[g] && idx <= GRP_HI[g]) r = GRP_LO[g];
        return r;
    endfunction

    function automatic int grp_last(input int idx);
        int r;
        r = idx;
        for (int g = 0; g < NGRP; g++)
            if (idx >= GRP_LO[g] && idx <= GRP_HI[g]) r = GRP_HI[g];
        return r;
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2c_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic scl_m, scl_s, scl_p;
    logic sda_m, sda_s, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            {scl_m, scl_s, scl_p} <= 3'b111;
            {sda_m, sda_s, sda_p} <= 3'b111;
        end else begin
            scl_m <= scl_in;
            scl_s <= scl_m;
            scl_p <= scl_s;
            sda_m <= sda_in;
            sda_s <= sda_m;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        evt.scl   = scl_s;
        evt.sda   = sda_s;
        evt.rise  = scl_s & ~scl_p;
        evt.fall  = ~scl_s & scl_p;
        evt.start = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_frame_fsm.sv
module i2c_frame_fsm
    import i2c_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_evt_t           evt,
    input  logic [1:0]         addr_sel,
    input  logic [NSTAT*8-1:0] status_in,
    output logic               sda_oe,
    output logic               frame_start,
    output wr_req_t            wr
);
    frame_state_e     st;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg, tx, rd_byte;
    logic [PTR_W-1:0] ptr;
    logic             rw, mack, full, receiving;

    assign full      = (bitcnt == 4'd8);
    assign receiving = (st == ST_ADDR) || (st == ST_SUB) || (st == ST_WDATA) || (st == ST_RDATA);

    always_comb begin
        rd_byte = 8'h00;
        if (int'(ptr) < NSTAT) rd_byte = status_in[int'(ptr)*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; bitcnt <= '0; shreg <= '0; tx <= '0; ptr <= '0;
            rw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0; frame_start <= 1'b0; wr <= '0;
        end else begin
            frame_start <= 1'b0;
            wr.en       <= 1'b0;
            if (evt.start) begin
                st <= ST_ADDR; bitcnt <= '0; sda_oe <= 1'b0; frame_start <= 1'b1;
            end else if (evt.stop) begin
                st <= ST_IDLE; sda_oe <= 1'b0;
            end else begin
                if (evt.rise && receiving) begin
                    shreg  <= {shreg[6:0], evt.sda};
                    bitcnt <= bitcnt + 4'd1;
                end
                case (st)
                    ST_ADDR: if (evt.fall && full) begin
                        if (shreg[7:1] == {DEV_PREFIX, addr_sel}) begin
                            sda_oe <= 1'b1; rw <= shreg[0]; st <= ST_ADDR_ACK;
                        end else st <= ST_IDLE;
                    end
                    ST_ADDR_ACK: if (evt.fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            tx <= rd_byte; sda_oe <= ~rd_byte[7]; st <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0; st <= ST_SUB;
                        end
                    end
                    ST_SUB: if (evt.fall && full) begin
                        ptr <= {1'b0, shreg};
                        if (target_ok({1'b0, shreg})) begin
                            sda_oe <= 1'b1; st <= ST_SUB_ACK;
                        end else st <= ST_IDLE;
                    end
                    ST_SUB_ACK: if (evt.fall) begin
                        sda_oe <= 1'b0; bitcnt <= '0; st <= ST_WDATA;
                    end
                    ST_WDATA: if (evt.fall && full) begin
                        if (target_ok(ptr)) begin
                            sda_oe <= 1'b1; st <= ST_WDATA_ACK;
                        end else st <= ST_IDLE;
                    end
                    ST_WDATA_ACK: begin
                        if (evt.rise) wr <= '{en: 1'b1, addr: ptr, data: shreg};
                        if (evt.fall) begin
                            sda_oe <= 1'b0; ptr <= ptr + 1'b1; bitcnt <= '0; st <= ST_WDATA;
                        end
                    end
                    ST_RDATA: if (evt.fall) begin
                        if (full) begin
                            sda_oe <= 1'b0; ptr <= ptr + 1'b1; st <= ST_RACK;
                        end else begin
                            tx <= {tx[6:0], 1'b1}; sda_oe <= ~tx[6];
                        end
                    end
                    ST_RACK: begin
                        if (evt.rise) mack <= ~evt.sda;
                        if (evt.fall) begin
                            bitcnt <= '0;
                            if (mack) begin
                                tx <= rd_byte; sda_oe <= ~rd_byte[7]; st <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0; st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  wr_req_t           wr,
    output logic [NREG*8-1:0] regs_out,
    output logic [7:0]        esp_out
);
    logic [7:0] live   [NREG];
    logic [7:0] shadow [NREG];
    logic [7:0] esp;
    int         tgt, g_lo, g_hi;

    always_comb begin
        tgt  = int'(wr.addr);
        g_lo = grp_first(tgt);
        g_hi = grp_last(tgt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            esp <= '0;
            for (int i = 0; i < NREG; i++) begin
                live[i]   <= '0;
                shadow[i] <= '0;
            end
        end else if (frame_start) begin
            for (int i = 0; i < NREG; i++) shadow[i] <= live[i];
        end else if (wr.en) begin
            if (tgt == ESP_ADDR) begin
                esp <= wr.data;
                for (int i = ESP_LO; i <= ESP_HI; i++) begin
                    live[i]   <= wr.data + 8'(i);
                    shadow[i] <= wr.data + 8'(i);
                end
            end else begin
                for (int i = 0; i < NREG; i++) begin
                    if (i == tgt) shadow[i] <= wr.data;
                    if (tgt == g_hi && i >= g_lo && i <= g_hi)
                        live[i] <= (i == tgt) ? wr.data : shadow[i];
                end
            end
        end
    end

    for (genvar k = 0; k < NREG; k++) begin : g_out
        assign regs_out[k*8 +: 8] = live[k];
    end
    assign esp_out = esp;
endmodule

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave
    import i2c_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [1:0]         addr_sel,
    input  logic [NSTAT*8-1:0] status_in,
    output logic               sda_oe,
    output logic [NREG*8-1:0]  regs_out,
    output logic [7:0]         esp_out
);
    bus_evt_t evt;
    wr_req_t  wr;
    logic     frame_start;

    i2c_bus_sync u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .evt(evt)
    );

    i2c_frame_fsm u_fsm (
        .clk(clk), .rst(rst), .evt(evt), .addr_sel(addr_sel), .status_in(status_in),
        .sda_oe(sda_oe), .frame_start(frame_start), .wr(wr)
    );

    i2c_reg_bank u_bank (
        .clk(clk), .rst(rst), .frame_start(frame_start), .wr(wr),
        .regs_out(regs_out), .esp_out(esp_out)
    );
endmodule

// File: rtl/i2c_ctrl_checker.sv
module i2c_ctrl_checker
    import i2c_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              start,
    input logic              stop,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [PTR_W-1:0]  wr_addr,
    input logic [NREG*8-1:0] regs_out
);
    assert_pull_while_low_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    assert_release_after_start_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> !sda_oe);

    assert_release_after_stop_R8: assert property (@(posedge clk) disable iff (rst)
        stop |=> !sda_oe);

    assert_commit_target_valid_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((int'(wr_addr) < NREG) || (int'(wr_addr) == ESP_ADDR)));

    assert_regs_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_out));
endmodule

bind i2c_ctrl_slave i2c_ctrl_checker u_chk (
    .clk(clk), .rst(rst), .scl_s(evt.scl), .start(evt.start), .stop(evt.stop),
    .sda_oe(sda_oe), .wr_en(wr.en), .wr_addr(wr.addr), .regs_out(regs_out)
);

// File: tb/i2c_ctrl_slave_test.sv
module i2c_ctrl_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 3;
    localparam int NREG       = 25;
    localparam int NSTAT      = 8;
    localparam logic [4:0] PFX = 5'b10110;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               scl_m = 1'b1;
    logic               sda_m = 1'b1;
    logic [1:0]         addr_sel = 2'b00;
    logic [NSTAT*8-1:0] status_in;
    logic               sda_oe;
    logic [NREG*8-1:0]  regs_out;
    logic [7:0]         esp_out;
    wire                sda_line = sda_m & ~sda_oe;

    int nvec = 0;
    int nbad = 0;
    logic [7:0] exp_reg [NREG];
    logic [7:0] wbuf [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ctrl_slave uut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .addr_sel(addr_sel),
        .status_in(status_in), .sda_oe(sda_oe), .regs_out(regs_out), .esp_out(esp_out)
    );

    function automatic logic [7:0] stat_val(input int k);
        return 8'h30 + 8'(k * 11);
    endfunction

    function automatic logic valid_sub(input int p);
        return (p < NREG) || (p == 255);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input logic b);
        wq(Q); sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); ack = ~sda_line; wq(Q); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); d[i] = sda_line; wq(Q); scl_m = 1'b0;
        end
        send_bit(~give_ack);
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++) chk(tag, 32'(regs_out[i*8 +: 8]), 32'(exp_reg[i]));
    endtask

    task automatic write_seq(input int sub, input int n, input string tag);
        logic a, ok;
        int p;
        i2c_start();
        send_byte({PFX, addr_sel, 1'b0}, a); chk({tag, " addr ack"}, 32'(a), 1);
        send_byte(8'(sub), a); ok = valid_sub(sub); chk({tag, " sub ack"}, 32'(a), 32'(ok));
        p = sub;
        for (int i = 0; i < n && ok; i++) begin
            send_byte(wbuf[i], a); ok = valid_sub(p); chk({tag, " data ack"}, 32'(a), 32'(ok));
            p++;
        end
        i2c_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        for (int k = 0; k < NSTAT; k++) status_in[k*8 +: 8] = stat_val(k);
        for (int i = 0; i < NREG; i++) exp_reg[i] = 8'h00;
        wq(5); rst = 1'b0; wq(2);

        // R9: reset state
        check_regs("R9 reset regs");
        chk("R9 reset esp", 32'(esp_out), 0);
        chk("R9 reset oe", 32'(sda_oe), 0);

        // R1: sweep every device address with one strap setting (includes broadcast 0)
        addr_sel = 2'b10;
        for (int a7 = 0; a7 < 128; a7++) begin
            i2c_start(); send_byte({7'(a7), 1'b0}, a); i2c_stop();
            chk("R1 address sweep", 32'(a), 32'(7'(a7) == {PFX, 2'b10}));
        end
        for (int s = 0; s < 4; s++) begin
            addr_sel = 2'(s);
            i2c_start(); send_byte({PFX, 2'(s), 1'b0}, a); i2c_stop();
            chk("R1 strap match", 32'(a), 1);
            chk("R8 released after stop", 32'(sda_oe), 0);
        end
        check_regs("R10 regs after address-only frames");

        // R2: consecutive stores
        addr_sel = 2'b01;
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3; wbuf[2] = 8'h96;
        write_seq(0, 3, "R2 run at 0");
        exp_reg[0] = 8'h5A; exp_reg[1] = 8'hC3; exp_reg[2] = 8'h96;
        check_regs("R2 run at 0");
        for (int i = 0; i < 4; i++) wbuf[i] = 8'(i * 37 + 5);
        write_seq(11, 4, "R2 run at 11");
        for (int i = 0; i < 4; i++) exp_reg[11 + i] = 8'(i * 37 + 5);
        check_regs("R2 run at 11");

        // R3: every subaddress, then the no-wrap boundary
        for (int s = 0; s < 256; s++) begin
            i2c_start(); send_byte({PFX, addr_sel, 1'b0}, a);
            send_byte(8'(s), a); i2c_stop();
            chk("R3 subaddress sweep", 32'(a), 32'(valid_sub(s)));
        end
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        write_seq(24, 2, "R3 past 24");
        exp_reg[24] = 8'h77;
        check_regs("R3 no wrap");

        // R4: partial group discarded, commit on last member
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        write_seq(3, 2, "R4 partial");
        check_regs("R4 partial group unchanged");
        i2c_start(); send_byte({PFX, addr_sel, 1'b0}, a); send_byte(8'd6, a);
        send_byte(8'hA1, a); chk("R4 ack", 32'(a), 1);
        chk("R4 mid group reg6", 32'(regs_out[6*8 +: 8]), 0);
        send_byte(8'hA2, a); chk("R4 ack", 32'(a), 1);
        chk("R4 mid group reg7", 32'(regs_out[7*8 +: 8]), 0);
        send_byte(8'hA3, a); chk("R4 ack", 32'(a), 1);
        i2c_stop();
        exp_reg[6] = 8'hA1; exp_reg[7] = 8'hA2; exp_reg[8] = 8'hA3;
        check_regs("R4 group 6 committed");
        wbuf[0] = 8'hB3; wbuf[1] = 8'hB4; wbuf[2] = 8'hB5;
        write_seq(3, 3, "R4 full group 3");
        exp_reg[3] = 8'hB3; exp_reg[4] = 8'hB4; exp_reg[5] = 8'hB5;
        check_regs("R4 group 3 committed");
        wbuf[0] = 8'hC4; wbuf[1] = 8'hC5;
        write_seq(4, 2, "R4 tail of group");
        exp_reg[4] = 8'hC4; exp_reg[5] = 8'hC5;
        check_regs("R4 tail keeps reg3");

        // R5: STOP before the acknowledge clock
        for (int n = 1; n <= 7; n++) begin
            i2c_start(); send_byte({PFX, addr_sel, 1'b0}, a); send_byte(8'd0, a);
            for (int b = 0; b < n; b++) send_bit(1'b1);
            i2c_stop();
            chk("R5 cut byte dropped", 32'(regs_out[7:0]), 32'(exp_reg[0]));
        end

        // R6: preset register
        wbuf[0] = 8'h40; wbuf[1] = 8'h99;
        write_seq(255, 2, "R6 preset");
        for (int k = 3; k <= 10; k++) exp_reg[k] = 8'h40 + 8'(k);
        check_regs("R6 preset fan-out");
        chk("R6 preset store", 32'(esp_out), 32'h40);

        // R7: reads with auto-increment past the status set
        i2c_start(); send_byte({PFX, addr_sel, 1'b0}, a); send_byte(8'd5, a);
        i2c_start(); send_byte({PFX, addr_sel, 1'b1}, a); chk("R7 read addr ack", 32'(a), 1);
        for (int k = 5; k <= 8; k++) begin
            recv_byte(k != 8, d);
            chk("R7 read byte", 32'(d), (k < NSTAT) ? 32'(stat_val(k)) : 0);
        end
        i2c_stop();
        chk("R8 released after read", 32'(sda_oe), 0);
        i2c_start(); send_byte({PFX, addr_sel, 1'b0}, a); send_byte(8'd0, a);
        i2c_start(); send_byte({PFX, addr_sel, 1'b1}, a);
        recv_byte(1'b1, d); chk("R7 read 0", 32'(d), 32'(stat_val(0)));
        recv_byte(1'b0, d); chk("R7 read 1", 32'(d), 32'(stat_val(1)));
        i2c_stop();
        i2c_start(); send_byte({PFX, addr_sel, 1'b1}, a);
        recv_byte(1'b0, d); chk("R7 read continues at 2", 32'(d), 32'(stat_val(2)));
        i2c_stop();
        check_regs("R10 regs after reads");
        chk("R6 preset kept", 32'(esp_out), 32'h40);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule